// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block holds the per-channel control and status bits of a multi-channel DMA engine and makes them reachable over a simple 32-bit register bus. Software can pause or resume any channel and can ask for a channel to be reset. It can also enable, inspect and acknowledge completion and error conditions. The channel engines report completion, termination and bus-error events, and they acknowledge reset requests, through per-channel input vectors.

Each of the three registers answers at three addresses: a plain write, a set alias that ORs the written ones into the register, and a clear alias that removes them. Software can therefore touch one channel's bits without a read-modify-write. Each channel drives its own interrupt line. That line is raised by an enabled completion or by any recorded error. A termination that arrives in the same cycle as a completion on the same channel is taken as a normal end and is not recorded as an error.

Reads are combinational: `rdata_o` follows `addr_i` without a strobe. A write takes effect at the rising clock edge on which `req_i` and `we_i` are both high.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every register bit reads 0, and `freeze_o`, `chan_rst_o` and `irq_o` are all 0.
- R2: The control register sits at byte offset 0x00, the interrupt register at 0x10 and the error register at 0x20. Inside each register, offset +0x0 is a plain write, +0x4 ORs in the written ones, and +0x8 clears the written ones. Reads at +0x0, +0x4 and +0x8 return the register value. Offset +0xC and the whole range 0x30..0x3F read 0, and writes to them change nothing.
- R3: Control bit n (0..15) is the freeze bit of channel n and drives `freeze_o[n]`. It changes only through a bus write.
- R4: Writing 1 to control bit 16+n through the plain or the set address raises `chan_rst_o[n]`. Writing 0, or writing through the clear alias, leaves these bits unchanged. The bit drops at the first clock edge at which `rst_ack_i[n]` is sampled high, unless a new request for channel n is written at that same edge.
- R5: Interrupt bit n is the completion flag of channel n and is set by `done_evt_i[n]`. Interrupt bit 16+n is its enable. Writing 0xFFFF0000 to the set alias (0x14) enables every channel.
- R6: Error bit n is set by `term_evt_i[n]` or by `buserr_evt_i[n]`. Error bit 16+n is set by `buserr_evt_i[n]` only. The per-channel error code, bit n plus bit 16+n, is therefore 0 for none, 1 for termination and 2 for bus error.
- R7: A termination event on channel n in the same cycle as `done_evt_i[n]` does not set error bit n. The completion flag is still set.
- R8: When an event and a software write or clear target the same flag bit at the same edge, the flag ends up set.
- R9: `irq_o[n]` is high exactly when (completion flag n AND enable n) OR error bit n holds. It first shows an event in the cycle after that event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable, qualified by req_i |
| addr_i | input | 6 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| done_evt_i | input | NUM_CH | Per-channel completion event pulse |
| term_evt_i | input | NUM_CH | Per-channel termination event pulse |
| buserr_evt_i | input | NUM_CH | Per-channel bus-error event pulse |
| rst_ack_i | input | NUM_CH | Per-channel acknowledge of a reset request |
| freeze_o | output | NUM_CH | Per-channel pause |
| chan_rst_o | output | NUM_CH | Per-channel reset request |
| irq_o | output | NUM_CH | Per-channel interrupt line |

## Verification
The collisions that matter are an engine event meeting a software clear or plain write of the same flag at the same edge, and a termination meeting a completion on one channel. Directed cycles drive a clear alias for a completion bit while the matching event pulses, and drive termination together with completion. Random cycles keep overlapping sparse events with writes at random aliases. The interrupt and error registers are then read back and compared with a bench model built from R5 to R8: the event must win, and a termination that completes in the same cycle must leave the error bit clear. The same approach covers a reset acknowledge that coincides with a new reset request.

// File: rtl/dma_chan_regs_pkg.sv
package dma_chan_regs_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned ADDR_W = 6;

  // register select, addr[5:4]
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_IRQ  = 2'd1;
  localparam logic [1:0] SEL_ERR  = 2'd2;

  // alias select, addr[3:2]
  localparam logic [1:0] ALIAS_WR  = 2'd0;
  localparam logic [1:0] ALIAS_SET = 2'd1;
  localparam logic [1:0] ALIAS_CLR = 2'd2;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } wr_op_e;

  function automatic logic apply_op(wr_op_e op, logic cur, logic wbit);
    logic res;
    unique case (op)
      OP_WRITE: res = wbit;
      OP_SET:   res = cur | wbit;
      OP_CLEAR: res = cur & ~wbit;
      default:  res = cur;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/dma_reg_decode.sv
module dma_reg_decode
  import dma_chan_regs_pkg::*;
(
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_op_e            ctrl_op_o,
  output wr_op_e            irq_op_o,
  output wr_op_e            err_op_o,
  output logic [1:0]        rd_sel_o,
  output logic              rd_hit_o
);

  logic [1:0] sel;
  logic [1:0] alias_sel;
  wr_op_e     op;
  logic       wr;

  assign sel       = addr_i[5:4];
  assign alias_sel = addr_i[3:2];
  assign wr        = req_i & we_i;

  always_comb begin
    unique case (alias_sel)
      ALIAS_WR:  op = OP_WRITE;
      ALIAS_SET: op = OP_SET;
      ALIAS_CLR: op = OP_CLEAR;
      default:   op = OP_NONE;
    endcase
  end

  assign ctrl_op_o = (wr && sel == SEL_CTRL) ? op : OP_NONE;
  assign irq_op_o  = (wr && sel == SEL_IRQ)  ? op : OP_NONE;
  assign err_op_o  = (wr && sel == SEL_ERR)  ? op : OP_NONE;

  assign rd_sel_o = sel;
  assign rd_hit_o = (alias_sel != 2'd3) && (sel != 2'd3);

endmodule

// File: rtl/dma_chan_slice.sv
module dma_chan_slice
  import dma_chan_regs_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  wr_op_e ctrl_op_i,
  input  wr_op_e irq_op_i,
  input  wr_op_e err_op_i,
  input  logic   w_lo_i,
  input  logic   w_hi_i,
  input  logic   done_evt_i,
  input  logic   term_evt_i,
  input  logic   buserr_evt_i,
  input  logic   rst_ack_i,
  output logic   freeze_o,
  output logic   rst_req_o,
  output logic   done_o,
  output logic   en_o,
  output logic   err_o,
  output logic   bus_o,
  output logic   irq_o
);

  logic freeze_q, rst_q, done_q, en_q, err_q, bus_q;
  logic freeze_d, rst_d, done_d, en_d, err_d, bus_d;
  logic rst_set, term_eff;

  // reset request only set by plain/set writes; clear alias has no effect
  assign rst_set  = w_hi_i && (ctrl_op_i == OP_WRITE || ctrl_op_i == OP_SET);
  // termination coinciding with completion is a normal end
  assign term_eff = term_evt_i & ~done_evt_i;

  always_comb begin
    freeze_d = apply_op(ctrl_op_i, freeze_q, w_lo_i);
    rst_d    = rst_set | (rst_q & ~rst_ack_i);
    done_d   = done_evt_i | apply_op(irq_op_i, done_q, w_lo_i);
    en_d     = apply_op(irq_op_i, en_q, w_hi_i);
    err_d    = buserr_evt_i | term_eff | apply_op(err_op_i, err_q, w_lo_i);
    bus_d    = buserr_evt_i | apply_op(err_op_i, bus_q, w_hi_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freeze_q <= 1'b0;
      rst_q    <= 1'b0;
      done_q   <= 1'b0;
      en_q     <= 1'b0;
      err_q    <= 1'b0;
      bus_q    <= 1'b0;
    end else begin
      freeze_q <= freeze_d;
      rst_q    <= rst_d;
      done_q   <= done_d;
      en_q     <= en_d;
      err_q    <= err_d;
      bus_q    <= bus_d;
    end
  end

  assign freeze_o  = freeze_q;
  assign rst_req_o = rst_q;
  assign done_o    = done_q;
  assign en_o      = en_q;
  assign err_o     = err_q;
  assign bus_o     = bus_q;
  assign irq_o     = (done_q & en_q) | err_q;

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_regs_pkg::*;
#(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_CH-1:0] done_evt_i,
  input  logic [NUM_CH-1:0] term_evt_i,
  input  logic [NUM_CH-1:0] buserr_evt_i,
  input  logic [NUM_CH-1:0] rst_ack_i,
  output logic [NUM_CH-1:0] freeze_o,
  output logic [NUM_CH-1:0] chan_rst_o,
  output logic [NUM_CH-1:0] irq_o
);

  wr_op_e      ctrl_op, irq_op, err_op;
  logic [1:0]  rd_sel;
  logic        rd_hit;
  logic [NUM_CH-1:0] done_q, en_q, err_q, bus_q;
  logic [DATA_W-1:0] ctrl_val, irq_val, err_val;

  dma_reg_decode u_decode (
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .ctrl_op_o (ctrl_op),
    .irq_op_o  (irq_op),
    .err_op_o  (err_op),
    .rd_sel_o  (rd_sel),
    .rd_hit_o  (rd_hit)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    dma_chan_slice u_slice (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .ctrl_op_i    (ctrl_op),
      .irq_op_i     (irq_op),
      .err_op_i     (err_op),
      .w_lo_i       (wdata_i[n]),
      .w_hi_i       (wdata_i[HALF_W+n]),
      .done_evt_i   (done_evt_i[n]),
      .term_evt_i   (term_evt_i[n]),
      .buserr_evt_i (buserr_evt_i[n]),
      .rst_ack_i    (rst_ack_i[n]),
      .freeze_o     (freeze_o[n]),
      .rst_req_o    (chan_rst_o[n]),
      .done_o       (done_q[n]),
      .en_o         (en_q[n]),
      .err_o        (err_q[n]),
      .bus_o        (bus_q[n]),
      .irq_o        (irq_o[n])
    );
  end

  always_comb begin
    ctrl_val = '0;
    irq_val  = '0;
    err_val  = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      ctrl_val[n]        = freeze_o[n];
      ctrl_val[HALF_W+n] = chan_rst_o[n];
      irq_val[n]         = done_q[n];
      irq_val[HALF_W+n]  = en_q[n];
      err_val[n]         = err_q[n];
      err_val[HALF_W+n]  = bus_q[n];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_hit) begin
      unique case (rd_sel)
        SEL_CTRL: rdata_o = ctrl_val;
        SEL_IRQ:  rdata_o = irq_val;
        SEL_ERR:  rdata_o = err_val;
        default:  rdata_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int unsigned NUM_CH = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [5:0]        addr_i,
  input logic [31:0]       rdata_o,
  input logic [NUM_CH-1:0] done_evt_i,
  input logic [NUM_CH-1:0] term_evt_i,
  input logic [NUM_CH-1:0] buserr_evt_i,
  input logic [NUM_CH-1:0] rst_ack_i,
  input logic [NUM_CH-1:0] freeze_o,
  input logic [NUM_CH-1:0] chan_rst_o,
  input logic [NUM_CH-1:0] irq_o,
  input logic [NUM_CH-1:0] done_q,
  input logic [NUM_CH-1:0] err_q
);

  logic wr;
  assign wr = req_i & we_i;

  assert_done_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_evt_i != '0) |=> (($past(done_evt_i) & ~done_q) == '0));

  assert_buserr_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buserr_evt_i != '0) |=> (($past(buserr_evt_i) & ~irq_o) == '0));

  assert_rst_selfclear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((rst_ack_i & chan_rst_o) != '0) && !wr) |=>
      (($past(rst_ack_i & chan_rst_o) & chan_rst_o) == '0));

  assert_freeze_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> $stable(freeze_o));

  assert_term_cancel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((term_evt_i & done_evt_i & ~buserr_evt_i & ~err_q) != '0) && !wr) |=>
      (($past(term_evt_i & done_evt_i & ~buserr_evt_i & ~err_q) & err_q) == '0));

  assert_reserved_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[5:4] == 2'd3 || addr_i[3:2] == 2'd3) |-> (rdata_o == '0));

endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .rdata_o      (rdata_o),
  .done_evt_i   (done_evt_i),
  .term_evt_i   (term_evt_i),
  .buserr_evt_i (buserr_evt_i),
  .rst_ack_i    (rst_ack_i),
  .freeze_o     (freeze_o),
  .chan_rst_o   (chan_rst_o),
  .irq_o        (irq_o),
  .done_q       (done_q),
  .err_q        (err_q)
);

// File: tb/dma_chan_regs_tb.sv
`timescale 1ns/1ps
module dma_chan_regs_tb;

  localparam int NCH = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [NCH-1:0] done_evt_i = '0, term_evt_i = '0, buserr_evt_i = '0, rst_ack_i = '0;
  logic [NCH-1:0] freeze_o, chan_rst_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] m_frz = '0, m_rst = '0, m_done = '0, m_en = '0, m_err = '0, m_bus = '0;

  always #2 clk_i = ~clk_i;

  dma_chan_regs #(.NUM_CH(NCH)) u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] alias16(input logic [1:0] al, input logic [15:0] cur,
                                          input logic [15:0] w);
    case (al)
      2'd0: return w;
      2'd1: return cur | w;
      2'd2: return cur & ~w;
      default: return cur;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [5:0] a);
    if (a[3:2] == 2'd3) return '0;
    case (a[5:4])
      2'd0: return {m_rst, m_frz};
      2'd1: return {m_en, m_done};
      2'd2: return {m_bus, m_err};
      default: return '0;
    endcase
  endfunction

  // one clock cycle with the given stimulus; model follows R2..R9
  task automatic cyc(input logic wr, input logic [5:0] a, input logic [31:0] wd,
                     input logic [15:0] de, input logic [15:0] te,
                     input logic [15:0] be, input logic [15:0] ak);
    logic [15:0] n_frz, n_rst, n_done, n_en, n_err, n_bus, rst_set, lo, hi;
    logic [1:0] al;
    logic [1:0] sel;
    req_i = wr; we_i = wr; addr_i = a; wdata_i = wd;
    done_evt_i = de; term_evt_i = te; buserr_evt_i = be; rst_ack_i = ak;
    lo = wd[15:0]; hi = wd[31:16]; al = a[3:2]; sel = a[5:4];
    n_frz = m_frz; n_done = m_done; n_en = m_en; n_err = m_err; n_bus = m_bus;
    rst_set = '0;
    if (wr && sel == 2'd0) begin
      n_frz = alias16(al, m_frz, lo);
      if (al == 2'd0 || al == 2'd1) rst_set = hi;
    end
    if (wr && sel == 2'd1) begin
      n_done = alias16(al, m_done, lo);
      n_en   = alias16(al, m_en, hi);
    end
    if (wr && sel == 2'd2) begin
      n_err = alias16(al, m_err, lo);
      n_bus = alias16(al, m_bus, hi);
    end
    n_rst  = rst_set | (m_rst & ~ak);
    n_done = n_done | de;
    n_err  = n_err | be | (te & ~de);
    n_bus  = n_bus | be;
    @(posedge clk_i);
    m_frz = n_frz; m_rst = n_rst; m_done = n_done; m_en = n_en; m_err = n_err; m_bus = n_bus;
    @(negedge clk_i);
    req_i = 0; we_i = 0;
    done_evt_i = '0; term_evt_i = '0; buserr_evt_i = '0; rst_ack_i = '0;
    chk("R3 freeze_o", {16'h0, freeze_o}, {16'h0, m_frz});
    chk("R4 chan_rst_o", {16'h0, chan_rst_o}, {16'h0, m_rst});
    chk("R9 irq_o", {16'h0, irq_o}, {16'h0, (m_done & m_en) | m_err});
  endtask

  task automatic rd(input string tag, input logic [5:0] a, input logic [31:0] exp);
    addr_i = a;
    #0.2;
    chk(tag, rdata_o, exp);
  endtask

  initial begin
    #150000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #0.2;
    // R1 reset state
    chk("R1 freeze/rst/irq", {chan_rst_o, freeze_o}, '0);
    chk("R1 irq_o", {16'h0, irq_o}, '0);
    rd("R1 ctrl", 6'h00, '0);
    rd("R1 irq reg", 6'h10, '0);
    rd("R1 err reg", 6'h20, '0);

    // R5 enable all through set alias
    cyc(1, 6'h14, 32'hFFFF_0000, '0, '0, '0, '0);
    rd("R5 enable-all readback", 6'h10, 32'hFFFF_0000);
    rd("R2 read set alias", 6'h14, 32'hFFFF_0000);

    // R8 event beats clear of completion flag
    cyc(0, 6'h00, '0, 16'h0008, '0, '0, '0);
    chk("R9 irq after done", {16'h0, irq_o}, 32'h0000_0008);
    cyc(1, 6'h18, 32'h0000_0008, 16'h0008, '0, '0, '0);
    rd("R8 event wins over clear", 6'h10, 32'hFFFF_0008);
    cyc(1, 6'h18, 32'h0000_0008, '0, '0, '0, '0);
    rd("R2 clear alias drops flag", 6'h10, 32'hFFFF_0000);

    // R7 termination with completion is no error
    cyc(0, 6'h00, '0, 16'h0020, 16'h0020, '0, '0);
    rd("R7 no error bit", 6'h20, 32'h0);
    rd("R7 completion kept", 6'h10, 32'hFFFF_0020);

    // R6 error codes
    cyc(0, 6'h00, '0, '0, 16'h0080, 16'h0004, '0);
    rd("R6 err reg codes", 6'h20, 32'h0004_0084);
    chk("R6 code ch2 bus", 32'(u_err_code(rdata_o, 2)), 32'd2);
    chk("R6 code ch7 term", 32'(u_err_code(rdata_o, 7)), 32'd1);
    cyc(1, 6'h28, 32'h0004_0084, '0, '0, '0, '0);
    rd("R6 clear errors", 6'h20, 32'h0);

    // R2 reserved space
    cyc(1, 6'h0C, 32'hFFFF_FFFF, '0, '0, '0, '0);
    rd("R2 write to +0xC ignored", 6'h00, 32'h0);
    cyc(1, 6'h30, 32'hFFFF_FFFF, '0, '0, '0, '0);
    rd("R2 reserved reads zero", 6'h30, 32'h0);
    rd("R2 +0xC reads zero", 6'h1C, 32'h0);

    // R4 reset request lifecycle
    cyc(1, 6'h00, 32'h0010_0000, '0, '0, '0, '0);
    chk("R4 request raised", {16'h0, chan_rst_o}, 32'h0010);
    cyc(1, 6'h08, 32'h0010_0000, '0, '0, '0, '0);
    chk("R4 clear alias ignored", {16'h0, chan_rst_o}, 32'h0010);
    cyc(1, 6'h00, 32'h0000_0000, '0, '0, '0, '0);
    chk("R4 write zero ignored", {16'h0, chan_rst_o}, 32'h0010);
    cyc(1, 6'h04, 32'h0010_0000, '0, '0, '0, 16'h0010);
    chk("R4 new request at ack kept", {16'h0, chan_rst_o}, 32'h0010);
    cyc(0, 6'h00, '0, '0, '0, '0, 16'h0010);
    chk("R4 ack clears", {16'h0, chan_rst_o}, 32'h0);

    // R3 freeze via set/clear
    cyc(1, 6'h04, 32'h0000_8001, '0, '0, '0, '0);
    chk("R3 freeze set", {16'h0, freeze_o}, 32'h8001);
    cyc(1, 6'h08, 32'h0000_0001, '0, '0, '0, '0);
    chk("R3 freeze clear", {16'h0, freeze_o}, 32'h8000);

    // random mix
    for (int i = 0; i < 2000; i++) begin
      logic wr;
      logic [5:0] a;
      logic [31:0] wd;
      wr = ($urandom % 3) == 0;
      a  = 6'(($urandom % 16) << 2);
      wd = $urandom;
      cyc(wr, a, wd,
          16'($urandom & $urandom),
          16'($urandom & $urandom & $urandom),
          16'($urandom & $urandom & $urandom & $urandom),
          16'($urandom));
      rd("R2 R5 R6 R8 random readback", a, exp_read(a));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic int u_err_code(input logic [31:0] v, input int ch);
    return int'(v[ch]) + int'(v[16+ch]);
  endfunction

endmodule